// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Port with Grouped Interrupts

This block is a 32-pin general-purpose I/O port that sits behind a simple single-cycle 32-bit register bus. Software uses it to choose, pin by pin, whether the pin is driven or left as an input. A driven pin either shows a software-set level or, with blinking turned on, a free-running square wave. Every pad input passes through a two-flop synchroniser. Each pin can then be inverted. The result is visible to software and also feeds interrupt detection.

Interrupt detection is per pin. A pin listed in the level mask latches its cause bit on every cycle that its conditioned input is high. Any other pin latches its cause bit on a rising edge of that input. Combining inversion with these two modes gives falling-edge and active-low sources. A pin is pending when its cause bit is set and it is enabled in either mask. The 32 pins form four groups of eight, and each group drives one active-high interrupt line that stays asserted while any pin in the group is pending. Software clears cause bits by writing zeros to them.

The blink timer is a two-state machine. It starts in `BLINK_DARK` after reset. The transition `BLINK_DARK -> BLINK_LIT` happens when its counter wraps, and the transition `BLINK_LIT -> BLINK_DARK` happens on the next wrap. The machine therefore changes state every 2^`BLINK_LOG2` clock cycles, which is 2^24 by default.

Top module: `gpio_port32`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0, control register reads 0xFFFFFFFF), all other registers read 0, and all four `irq_grp` lines are low.
- R2: Registers sit at byte addresses 0x00 data out, 0x04 direction control, 0x08 blink select, 0x0C input inversion, 0x10 conditioned input, 0x14 cause, 0x18 edge enable and 0x1C level enable, decoded from `bus_addr[4:2]`. A write lands on the clock edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` shows the addressed register combinationally, and writes to 0x10 have no effect.
- R3: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 drives the pin (`pad_oe` bit 1). For a pin without blink, `pad_out` equals its data-out bit.
- R4: A pin whose blink bit is set drives its data-out bit ANDed with the blink phase. The phase is 0 for the first 2^`BLINK_LOG2` cycles after reset and then inverts every 2^`BLINK_LOG2` cycles.
- R5: The register at 0x10 reads the pad input delayed by two clock edges and XORed with the inversion register.
- R6: For a pin whose level-enable bit is 0, its cause bit is set on the edge after the conditioned input goes from 0 to 1, whatever its edge-enable bit is.
- R7: For a pin whose level-enable bit is 1, its cause bit is set on every cycle that its conditioned input is 1, so a held source sets the bit again after it is cleared.
- R8: Writing to 0x14 ANDs the cause register with the written value: a 0 clears that bit and a 1 leaves it alone. An event in the same cycle as the write wins over the clear.
- R9: `irq_grp[g]` is high while any pin 8g..8g+7 has its cause bit set together with its edge-enable or level-enable bit.
- R10: With the inversion bit set and the pin in edge mode, a falling pad level sets the cause bit. Changing the inversion bit also changes the conditioned input, so it can itself produce an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for `bus_sel` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad driver enable, 1 drives |
| irq_grp | output | 4 | Level interrupt per group of eight pins |

## Verification
The embedded properties assume that `rst_n` is the only reset. They also assume that a bus write is a one-cycle strobe whose data is stable at the clock edge. Pad inputs are allowed to change at any time, because the synchroniser absorbs them. The bench changes pad levels and bus signals only on falling clock edges, and it reads the conditioned input only through the register bus. It shortens the blink period through `BLINK_LOG2` so that several phase changes fit in the run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        REG_DOUT  = 3'd0,
        REG_DIR   = 3'd1,
        REG_BLINK = 3'd2,
        REG_INV   = 3'd3,
        REG_DIN   = 3'd4,
        REG_CAUSE = 3'd5,
        REG_EDGE  = 3'd6,
        REG_LEVEL = 3'd7
    } gpio_reg_e;

    typedef enum logic {
        BLINK_DARK = 1'b0,
        BLINK_LIT  = 1'b1
    } blink_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer
    import gpio_pkg::*;
#(
    parameter int BLINK_LOG2 = 24
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam logic [BLINK_LOG2-1:0] WRAP = '1;

    logic [BLINK_LOG2-1:0] cnt_q;
    blink_state_e          state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            state_q <= BLINK_DARK;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLINK_DARK: if (cnt_q == WRAP) state_d = BLINK_LIT;
            BLINK_LIT:  if (cnt_q == WRAP) state_d = BLINK_DARK;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BLINK_DARK: phase = 1'b0;
            BLINK_LIT:  phase = 1'b1;
        endcase
    end

    // R4: the phase may only move when the counter has just wrapped
    assert_phase_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> ($past(cnt_q) == WRAP));
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
    parameter int NPINS = 32,
    parameter int GRP   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      cond_in,
    input  logic [NPINS-1:0]      edge_en,
    input  logic [NPINS-1:0]      level_en,
    input  logic                  clr_wr,
    input  logic [NPINS-1:0]      clr_keep,
    output logic [NPINS-1:0]      cause,
    output logic [NPINS/GRP-1:0]  irq_grp
);
    localparam int NGRP = NPINS / GRP;

    logic [NPINS-1:0] prev_q, cause_q, rise, hit, keep;

    assign rise = cond_in & ~prev_q;
    assign hit  = (rise & ~level_en) | (cond_in & level_en);
    assign keep = clr_wr ? clr_keep : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= cond_in;
            cause_q <= (cause_q & keep) | hit;
        end
    end

    assign cause = cause_q;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_grp[g] = |(cause_q[g*GRP +: GRP] & (edge_en[g*GRP +: GRP] | level_en[g*GRP +: GRP]));
    end

    // R8: without a cause write no latched bit is lost
    assert_cause_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(cause_q) & ~cause_q) == '0));

    // R6: a rising conditioned input on an edge-mode pin latches its cause
    assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_in & ~prev_q & ~level_en) != '0) |=>
        ((cause_q & $past(cond_in & ~prev_q & ~level_en)) == $past(cond_in & ~prev_q & ~level_en)));

    // R7: a high level-mode input latches its cause even across a clear
    assert_level_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_in & level_en) != '0) |=>
        ((cause_q & $past(cond_in & level_en)) == $past(cond_in & level_en)));
endmodule

// File: rtl/gpio_port32.sv
module gpio_port32
    import gpio_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int GRP        = 8,
    parameter int ADDR_W     = 5,
    parameter int BLINK_LOG2 = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NPINS-1:0]     bus_wdata,
    output logic [NPINS-1:0]     bus_rdata,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS/GRP-1:0] irq_grp
);
    localparam int NGRP = NPINS / GRP;

    gpio_reg_e        sel_reg;
    logic             wr_stb;
    logic [NPINS-1:0] dout_q, dir_q, blink_q, inv_q, edge_q, level_q;
    logic [NPINS-1:0] sync_in, cond_in, cause;
    logic [NGRP-1:0]  grp_irq;
    logic             phase;

    assign sel_reg = gpio_reg_e'(bus_addr[4:2]);
    assign wr_stb  = bus_sel & bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            inv_q   <= '0;
            edge_q  <= '0;
            level_q <= '0;
        end else if (wr_stb) begin
            unique case (sel_reg)
                REG_DOUT:  dout_q  <= bus_wdata;
                REG_DIR:   dir_q   <= bus_wdata;
                REG_BLINK: blink_q <= bus_wdata;
                REG_INV:   inv_q   <= bus_wdata;
                REG_EDGE:  edge_q  <= bus_wdata;
                REG_LEVEL: level_q <= bus_wdata;
                REG_DIN, REG_CAUSE: ;
            endcase
        end
    end

    gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(sync_in)
    );

    assign cond_in = sync_in ^ inv_q;

    gpio_irq_core #(.NPINS(NPINS), .GRP(GRP)) u_irq (
        .clk(clk), .rst_n(rst_n), .cond_in(cond_in),
        .edge_en(edge_q), .level_en(level_q),
        .clr_wr(wr_stb && (sel_reg == REG_CAUSE)), .clr_keep(bus_wdata),
        .cause(cause), .irq_grp(grp_irq)
    );

    gpio_blink_timer #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
        .clk(clk), .rst_n(rst_n), .phase(phase)
    );

    assign irq_grp = grp_irq;
    assign pad_oe  = ~dir_q;
    assign pad_out = (dout_q & ~blink_q) | (dout_q & blink_q & {NPINS{phase}});

    always_comb begin
        unique case (sel_reg)
            REG_DOUT:  bus_rdata = dout_q;
            REG_DIR:   bus_rdata = dir_q;
            REG_BLINK: bus_rdata = blink_q;
            REG_INV:   bus_rdata = inv_q;
            REG_DIN:   bus_rdata = cond_in;
            REG_CAUSE: bus_rdata = cause;
            REG_EDGE:  bus_rdata = edge_q;
            REG_LEVEL: bus_rdata = level_q;
        endcase
    end

    // R9: no group line is raised while none of its pins is enabled
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_q | level_q) == '0) |-> (irq_grp == '0));

    // R2: a write to the conditioned-input address leaves every register as it was
    assert_din_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && sel_reg == REG_DIN) |=>
        $stable(dout_q) && $stable(dir_q) && $stable(blink_q) && $stable(inv_q) && $stable(edge_q) && $stable(level_q));
endmodule

// File: tb/gpio_port32_test.sv
module gpio_port32_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, pad_in = '0;
    logic [31:0] bus_rdata, pad_out, pad_oe;
    logic [3:0]  irq_grp;

    gpio_port32 #(.BLINK_LOG2(NB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit cmp_on = 0, done = 0;
    string tag = "R1";

    // behavioural reference state
    logic [31:0] m_dout, m_dir, m_blink, m_inv, m_cause, m_edge, m_level, m_s1, m_s2, m_prev;
    int m_ticks;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dout = 0; m_dir = '1; m_blink = 0; m_inv = 0; m_cause = 0;
            m_edge = 0; m_level = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_ticks = 0;
        end else begin
            logic [31:0] c, ev, keep;
            c    = m_s2 ^ m_inv;
            ev   = ((c & ~m_prev) & ~m_level) | (c & m_level);
            keep = (bus_sel && bus_wr && bus_addr[4:2] == 3'd5) ? bus_wdata : '1;
            m_cause = (m_cause & keep) | ev;
            m_prev = c; m_s2 = m_s1; m_s1 = pad_in;
            if (bus_sel && bus_wr) begin
                case (bus_addr[4:2])
                    3'd0: m_dout = bus_wdata;
                    3'd1: m_dir = bus_wdata;
                    3'd2: m_blink = bus_wdata;
                    3'd3: m_inv = bus_wdata;
                    3'd6: m_edge = bus_wdata;
                    3'd7: m_level = bus_wdata;
                    default: ;
                endcase
            end
            m_ticks++;
        end
    end

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_dout;
            3'd1: return m_dir;
            3'd2: return m_blink;
            3'd3: return m_inv;
            3'd4: return m_s2 ^ m_inv;
            3'd5: return m_cause;
            3'd6: return m_edge;
            default: return m_level;
        endcase
    endfunction

    task automatic check(string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            logic [31:0] ph, pend;
            logic [3:0]  eirq;
            ph   = ((m_ticks >> NB) & 1) != 0 ? '1 : '0;
            pend = m_cause & (m_edge | m_level);
            for (int g = 0; g < 4; g++) eirq[g] = |pend[g*8 +: 8];
            check("bus_rdata", bus_rdata, exp_rd(bus_addr[4:2]));
            check("pad_oe", pad_oe, ~m_dir);
            check("pad_out", pad_out, (m_dout & ~m_blink) | (m_dout & m_blink & ph));
            check("irq_grp", {28'd0, irq_grp}, {28'd0, eirq});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic look(logic [4:0] a);
        @(negedge clk);
        bus_addr = a;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1: reset values through the bus and the pins
        tag = "R1";
        for (int a = 0; a < 8; a++) begin
            bus_addr = 5'(a * 4);
            #1;
            check("reset readback", bus_rdata, (a == 1) ? 32'hFFFF_FFFF : 32'h0);
        end
        check("reset pad_oe", pad_oe, 32'h0);
        check("reset irq", {28'd0, irq_grp}, 32'h0);
        cmp_on = 1;

        tag = "R2";
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_00FF);
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h18, 32'h1234_0000);
        wr(5'h1C, 32'h0000_0000);
        for (int a = 0; a < 8; a++) look(5'(a * 4));
        wr(5'h18, 32'h0);

        tag = "R3";
        wr(5'h04, 32'h0000_FFFF);
        wr(5'h00, 32'h1234_ABCD);
        idle(3);

        tag = "R4";
        wr(5'h08, 32'h0F00_00F0);
        idle(40);
        wr(5'h00, 32'h0);
        idle(10);
        wr(5'h08, 32'h0);

        tag = "R5";
        look(5'h10);
        wr(5'h0C, 32'h00FF_00FF);
        pad_in = 32'hF0F0_F0F0; idle(3);
        pad_in = 32'h0F0F_1234; idle(3);
        pad_in = 32'h0; idle(3);

        tag = "R6";
        wr(5'h0C, 32'h0);
        idle(3);
        wr(5'h14, 32'h0);
        wr(5'h18, 32'h0000_00FF);
        look(5'h14);
        pad_in = 32'h0000_0055; idle(3);
        pad_in = 32'h0000_00AA; idle(3);
        pad_in = 32'h0; idle(3);

        tag = "R7";
        wr(5'h1C, 32'h0000_FF00);
        pad_in = 32'h0000_0300; idle(4);
        wr(5'h14, 32'h0);
        idle(2);
        pad_in = 32'h0; idle(3);
        wr(5'h14, 32'hFFFF_00FF);
        idle(2);

        tag = "R8";
        pad_in = 32'hFFFF_0000; idle(3);
        wr(5'h14, 32'h0F0F_0000);
        idle(2);
        wr(5'h14, 32'h0);
        pad_in = 32'h0; idle(3);

        tag = "R9";
        wr(5'h1C, 32'h0);
        wr(5'h18, 32'hFF00_0001);
        wr(5'h14, 32'h0);
        pad_in = 32'h8000_0001; idle(4);
        wr(5'h14, 32'hFFFF_FFFE);
        idle(2);
        wr(5'h14, 32'h0);
        pad_in = 32'h0; idle(3);

        tag = "R10";
        wr(5'h18, 32'h0000_0100);
        pad_in = 32'h0000_0100; idle(3);
        wr(5'h0C, 32'h0000_0100);
        idle(3);
        wr(5'h14, 32'h0);
        pad_in = 32'h0; idle(4);
        wr(5'h14, 32'h0);
        idle(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule